// File: doc/BRIEF.md
# Free-Running Up/Down Event Counter

This block counts events with a 16-bit register that never reloads. An event is either a selected edge of an external input pin or a single-cycle overflow pulse from a neighbouring timer. The count goes up or down. When it passes the end of its range it wraps to the other end, keeps counting and raises a sticky interrupt request. A small register interface loads the count and reads it back. The same interface sets the control bits and clears the request.

The count direction comes from a control flag or from the level of a separate direction pin; software picks which. A direction change made between events does not touch the count; the new direction applies from the next qualifying event. The external event pin and the direction pin are each synchronised by two flops. Edges are found in the system clock domain, so the counter moves by at most one step per clock. As an option, an output pin toggles on every wrap.

Register map (`reg_addr`): 0 is the count, read and write. 1 is the control byte. 2 is the status: bit 0 is the request, and writing 1 to it clears the request. Reads of address 3 return zero.

Top module: `evt_wrap_counter`

## Requirements
- R1: After reset the count, the control register, the status register, `irq_req` and `pulse_out` are all zero.
- R2: A write to address 0 loads the full 16-bit count, and a read of address 0 returns it.
- R3: Events change the count only while control bit 0 (run) is 1. With run at 0, pin edges leave the count unchanged.
- R4: With control bit 1 (edge select) at 0, the count advances on a falling edge of the event pin, and a rising edge does nothing. With bit 1 at 1, the count advances on a rising edge, and a falling edge does nothing. A pin change shows in the count within four clock cycles.
- R5: Control bit 3 chooses the direction source. At 0, control bit 2 sets the direction: 1 counts up, 0 counts down. At 1, the level of `dir_pin` sets it: high counts up, low counts down.
- R6: A down step from 0x0000 gives 0xFFFF and sets the request. Later steps keep counting down from 0xFFFF.
- R7: An up step from 0xFFFF gives 0x0000 and sets the request. Later steps keep counting up from 0x0000.
- R8: The request stays at 1 until one of two things happens: `irq_ack` is high for one cycle, or software writes address 2 with bit 0 set. A write to address 2 with bit 0 clear leaves the request unchanged.
- R9: Changing the direction while counting leaves the count unchanged until the next qualifying event, and that event steps in the new direction.
- R10: With control bit 4 (source select) at 1, each clock cycle in which `nbr_ovf` is high counts one step, and event-pin edges are ignored.
- R11: With control bit 5 (pulse enable) at 1, `pulse_out` toggles on each wrap. With bit 5 at 0, `pulse_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_pin | input | 1 | External event input (asynchronous) |
| dir_pin | input | 1 | External direction level (asynchronous); high counts up |
| nbr_ovf | input | 1 | Single-cycle overflow pulse from a neighbouring timer (synchronous) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on `reg_addr`) |
| irq_ack | input | 1 | Interrupt acknowledge; clears the request |
| irq_req | output | 1 | Sticky wrap request |
| pulse_out | output | 1 | Toggle output on wrap |

## Verification
The bench sweeps every combination of edge polarity, direction source and direction. In each combination it starts the count one step short of the boundary and drives it across. After every half-pulse of the pin it checks the count and the request. A design with the polarity inverted would count on the idle-going half and fail the check on the unchanged half. A design that reloads, or wraps to the wrong end, would show a wrong value right after the boundary. A design that read the wrong direction source would count the wrong way, because the flag and the pin are always set to opposite directions. Further tests cover the following:
- The request survives a write with bit 0 clear.
- A direction change without an event leaves the count unchanged.
- Pin toggles are ignored while the neighbour source is selected.
- `pulse_out` stays low across a wrap when the option is off.

// File: rtl/evc_pkg.sv
package evc_pkg;

  // Control register layout: run is bit 0, pulse enable is bit 5.
  typedef struct packed {
    logic pulse_en;
    logic src_nbr;
    logic dir_pin_sel;
    logic dir_up;
    logic rise_sel;
    logic run;
  } evc_ctrl_t;

  typedef enum logic [1:0] {
    ADDR_COUNT = 2'd0,
    ADDR_CTRL  = 2'd1,
    ADDR_STAT  = 2'd2,
    ADDR_RSVD  = 2'd3
  } evc_addr_e;

endpackage

// File: rtl/evc_sync.sv
module evc_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/evc_edge.sv
module evc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic rise_sel,
  input  logic src_nbr,
  input  logic nbr_ovf,
  output logic evt
);

  logic prev_q, prev_d;
  logic rise_e, fall_e, pin_evt;

  always_comb begin
    prev_d  = pin_s;
    rise_e  = pin_s & ~prev_q;
    fall_e  = ~pin_s & prev_q;
    pin_evt = rise_sel ? rise_e : fall_e;
    evt     = src_nbr ? nbr_ovf : pin_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

endmodule

// File: rtl/evc_core.sv
module evc_core #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             evt,
  input  logic             dir_up,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             irq_clr,
  input  logic             pulse_en,
  output logic [WIDTH-1:0] count,
  output logic             irq,
  output logic             pulse
);

  localparam logic [WIDTH-1:0] MAX_VAL = '1;
  localparam logic [WIDTH-1:0] MIN_VAL = '0;
  localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;
  logic             pls_q, pls_d;
  logic             step, wrap, cnt_en;

  always_comb begin
    step   = run & evt & ~load;
    wrap   = step & (dir_up ? (cnt_q == MAX_VAL) : (cnt_q == MIN_VAL));
    cnt_en = load | step;
    if (load) begin
      cnt_d = load_val;
    end else if (dir_up) begin
      cnt_d = cnt_q + ONE;
    end else begin
      cnt_d = cnt_q - ONE;
    end
    // a wrap in the same cycle as a clear keeps the request set
    if (wrap) begin
      irq_d = 1'b1;
    end else if (irq_clr) begin
      irq_d = 1'b0;
    end else begin
      irq_d = irq_q;
    end
    if (!pulse_en) begin
      pls_d = 1'b0;
    end else if (wrap) begin
      pls_d = ~pls_q;
    end else begin
      pls_d = pls_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      pls_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      pls_q <= pls_d;
    end
  end

  assign count = cnt_q;
  assign irq   = irq_q;
  assign pulse = pls_q;

endmodule

// File: rtl/evt_wrap_counter.sv
module evt_wrap_counter
  import evc_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_pin,
  input  logic             dir_pin,
  input  logic             nbr_ovf,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [WIDTH-1:0] reg_wdata,
  output logic [WIDTH-1:0] reg_rdata,
  input  logic             irq_ack,
  output logic             irq_req,
  output logic             pulse_out
);

  localparam int CTRL_W = $bits(evc_ctrl_t);

  logic             rst_n_sync;
  logic [1:0]       pins_s;
  evc_ctrl_t        ctrl_q, ctrl_d;
  logic             ctrl_we, cnt_load, irq_clr, dir_up, evt_qual;
  logic             irq_flag, pulse_q;
  logic [WIDTH-1:0] cnt_val;

  evc_sync #(.STAGES(2), .W(1)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_n_sync)
  );

  evc_sync #(.STAGES(SYNC_STAGES), .W(2)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .d     ({dir_pin, evt_pin}),
    .q     (pins_s)
  );

  always_comb begin
    ctrl_we  = reg_we && (reg_addr == ADDR_CTRL);
    cnt_load = reg_we && (reg_addr == ADDR_COUNT);
    irq_clr  = irq_ack || (reg_we && (reg_addr == ADDR_STAT) && reg_wdata[0]);
    ctrl_d   = evc_ctrl_t'(reg_wdata[CTRL_W-1:0]);
    dir_up   = ctrl_q.dir_pin_sel ? pins_s[1] : ctrl_q.dir_up;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  evc_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .pin_s    (pins_s[0]),
    .rise_sel (ctrl_q.rise_sel),
    .src_nbr  (ctrl_q.src_nbr),
    .nbr_ovf  (nbr_ovf),
    .evt      (evt_qual)
  );

  evc_core #(.WIDTH(WIDTH)) u_core (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .run      (ctrl_q.run),
    .evt      (evt_qual),
    .dir_up   (dir_up),
    .load     (cnt_load),
    .load_val (reg_wdata),
    .irq_clr  (irq_clr),
    .pulse_en (ctrl_q.pulse_en),
    .count    (cnt_val),
    .irq      (irq_flag),
    .pulse    (pulse_q)
  );

  always_comb begin
    case (evc_addr_e'(reg_addr))
      ADDR_COUNT: reg_rdata = cnt_val;
      ADDR_CTRL:  reg_rdata = WIDTH'(ctrl_q);
      ADDR_STAT:  reg_rdata = WIDTH'(irq_flag);
      default:    reg_rdata = '0;
    endcase
  end

  assign irq_req   = irq_flag;
  assign pulse_out = pulse_q;

endmodule

// File: rtl/evt_wrap_counter_chk.sv
module evt_wrap_counter_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] count,
  input logic             load,
  input logic             run,
  input logic             irq,
  input logic             irq_clr,
  input logic             pulse_en,
  input logic             pulse_out
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (count == $past(count) || count == $past(count) + ONE
               || count == $past(count) - ONE));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(count));

  // R7
  up_wrap_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && count == '1) |=> (count != '0 || irq));

  // R6
  down_wrap_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && count == '0) |=> (count != '1 || irq));

  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  // R11
  pulse_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_en && pulse_out != $past(pulse_out)) |-> irq);

endmodule

bind evt_wrap_counter evt_wrap_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .count     (cnt_val),
  .load      (cnt_load),
  .run       (ctrl_q.run),
  .irq       (irq_flag),
  .irq_clr   (irq_clr),
  .pulse_en  (ctrl_q.pulse_en),
  .pulse_out (pulse_q)
);

// File: tb/evt_wrap_counter_bench.sv
module evt_wrap_counter_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_pin, dir_pin, nbr_ovf, reg_we, irq_ack;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        irq_req, pulse_out;
  int          total = 0;
  int          bad   = 0;

  always #4 clk = ~clk;

  evt_wrap_counter u_evt_wrap_counter (
    .clk(clk), .rst_n(rst_n), .evt_pin(evt_pin), .dir_pin(dir_pin),
    .nbr_ovf(nbr_ovf), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack),
    .irq_req(irq_req), .pulse_out(pulse_out)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pin_to(input logic lvl);
    @(negedge clk);
    evt_pin = lvl;
    repeat (4) @(posedge clk);
  endtask

  task automatic full_pulse(input logic idle);
    pin_to(~idle);
    pin_to(idle);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v, exp, ctl;
    logic        idle, flag, wrapped;
    rst_n = 1'b0; evt_pin = 1'b1; dir_pin = 1'b0; nbr_ovf = 1'b0;
    reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0; irq_ack = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1", "count", v, 16'h0000);
    rd(2'd1, v); chk("R1", "ctrl", v, 16'h0000);
    rd(2'd2, v); chk("R1", "status", v, 16'h0000);
    chk("R1", "irq_req", {15'd0, irq_req}, 16'h0000);
    chk("R1", "pulse_out", {15'd0, pulse_out}, 16'h0000);

    // R2 load and read back
    wr(2'd0, 16'hA5C3); rd(2'd0, v); chk("R2", "load", v, 16'hA5C3);
    wr(2'd0, 16'h5A3C); rd(2'd0, v); chk("R2", "load", v, 16'h5A3C);

    // R4 R5 R6 R7 sweep over polarity, direction source and direction
    for (int pol = 0; pol < 2; pol++) begin
      for (int dsrc = 0; dsrc < 2; dsrc++) begin
        for (int up = 0; up < 2; up++) begin
          idle = (pol == 0);
          flag = (dsrc == 1) ? (up == 0) : (up == 1);
          ctl  = 16'((dsrc << 3) | (int'(flag) << 2) | (pol << 1));
          wr(2'd1, ctl);
          @(negedge clk);
          evt_pin = idle;
          dir_pin = (dsrc == 1) ? (up == 1) : (up == 0);
          repeat (5) @(posedge clk);
          exp = (up == 1) ? 16'hFFFE : 16'h0001;
          wr(2'd0, exp);
          wr(2'd2, 16'h0001);
          wr(2'd1, ctl | 16'h0001);
          wrapped = 1'b0;
          for (int k = 1; k <= 4; k++) begin
            pin_to(~idle);
            exp = (up == 1) ? exp + 16'd1 : exp - 16'd1;
            if (k == 2) wrapped = 1'b1;
            rd(2'd0, v);
            chk((up == 1) ? "R7" : "R6", "count after edge", v, exp);
            chk("R5", "direction", v, exp);
            chk((up == 1) ? "R7" : "R6", "irq", {15'd0, irq_req}, {15'd0, wrapped});
            pin_to(idle);
            rd(2'd0, v);
            chk("R4", "opposite edge ignored", v, exp);
          end
        end
      end
    end

    // R8 sticky request and its clears
    wr(2'd2, 16'h0000);
    chk("R8", "write 0 keeps", {15'd0, irq_req}, 16'h0001);
    @(negedge clk) irq_ack = 1'b1;
    @(negedge clk) irq_ack = 1'b0;
    chk("R8", "ack clears", {15'd0, irq_req}, 16'h0000);
    wr(2'd1, 16'h0000);
    pin_to(1'b1);
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0001);
    full_pulse(1'b1);
    chk("R8", "set again", {15'd0, irq_req}, 16'h0001);
    repeat (6) @(posedge clk);
    chk("R8", "held", {15'd0, irq_req}, 16'h0001);
    wr(2'd2, 16'h0001);
    chk("R8", "write 1 clears", {15'd0, irq_req}, 16'h0000);

    // R3 run bit off ignores edges
    wr(2'd1, 16'h0004);
    wr(2'd0, 16'h1234);
    full_pulse(1'b1); full_pulse(1'b1);
    rd(2'd0, v); chk("R3", "stopped", v, 16'h1234);

    // R9 deferred direction change
    wr(2'd1, 16'h0005);
    wr(2'd0, 16'h0100);
    full_pulse(1'b1);
    rd(2'd0, v); chk("R9", "up step", v, 16'h0101);
    wr(2'd1, 16'h0001);
    repeat (6) @(posedge clk);
    rd(2'd0, v); chk("R9", "no change before edge", v, 16'h0101);
    full_pulse(1'b1);
    rd(2'd0, v); chk("R9", "new direction", v, 16'h0100);

    // R10 neighbour overflow source
    wr(2'd1, 16'h0015);
    wr(2'd0, 16'h0010);
    full_pulse(1'b1); full_pulse(1'b1);
    rd(2'd0, v); chk("R10", "pin ignored", v, 16'h0010);
    @(negedge clk) nbr_ovf = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk) nbr_ovf = 1'b0;
    repeat (2) @(posedge clk);
    rd(2'd0, v); chk("R10", "nbr count", v, 16'h0015);

    // R11 toggle output
    wr(2'd1, 16'h0025);
    wr(2'd0, 16'hFFFF);
    full_pulse(1'b1);
    chk("R11", "toggle high", {15'd0, pulse_out}, 16'h0001);
    rd(2'd0, v); chk("R7", "wrap to zero", v, 16'h0000);
    full_pulse(1'b1);
    chk("R11", "no toggle mid-range", {15'd0, pulse_out}, 16'h0001);
    wr(2'd0, 16'hFFFF);
    full_pulse(1'b1);
    chk("R11", "toggle low", {15'd0, pulse_out}, 16'h0000);
    wr(2'd1, 16'h0005);
    wr(2'd0, 16'hFFFF);
    full_pulse(1'b1);
    chk("R11", "disabled stays low", {15'd0, pulse_out}, 16'h0000);
    chk("R7", "irq on disabled wrap", {15'd0, irq_req}, 16'h0001);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule